// File: doc/BRIEF.md
# 64-bit SECDED Codec

This block protects 64-bit words with a single-error-correct, double-error-detect Hamming code. The encode side takes a data word and produces a 72-bit codeword: the data, seven Hamming check bits and one overall parity bit. That codeword is ready to be written to a memory. The decode side takes a 72-bit codeword read back from that memory. It returns the data, corrects any one flipped bit, and reports an error that cannot be corrected.

Parameters enable the encode side, the decode side, or both. They also choose whether the decode results pass through one output register. The encode side has a fault-injection feature: one or two chosen codeword bits can be inverted on their way out, so that the correction and detection paths can be exercised in a running system. The storage array itself is not part of this block.

Top module: `ecc64_codec`

## Requirements
- R1: With encoding enabled and no injection, `enc_cw_o[63:0]` equals the data. `enc_cw_o[64+k]` (k = 0..6) is the XOR of every data bit i whose Hamming position has bit k set. Data bits take the positions 3, 5, 6, 7, 9, … in ascending order, skipping powers of two. `enc_cw_o[71]` is the XOR of bits 70..0, so the whole codeword has even parity.
- R2: With `inj_one_i` high and `inj_two_i` low, codeword bit `inj_pos_a_i` is inverted on `enc_cw_o`. A position of 72 or more inverts nothing.
- R3: With `inj_two_i` high, bits `inj_pos_a_i` and `inj_pos_b_i` are both inverted, whatever the value of `inj_one_i`.
- R4: A codeword with no error decodes to its data bits, with both flags low.
- R5: A codeword with any one of bits 0..70 inverted decodes to the original data, with `dec_sbe_o` high and `dec_dbe_o` low.
- R6: A codeword with only bit 71 inverted decodes to the correct data, with `dec_sbe_o` high.
- R7: A codeword with any two bits inverted raises `dec_dbe_o` with `dec_sbe_o` low. The data bits `dec_cw_i[63:0]` are passed through unchanged.
- R8: With OUT_REG = 1, the decode outputs change one clock after `dec_cw_i` changes, and reset clears them to zero. With OUT_REG = 0 they follow `dec_cw_i` in the same cycle.
- R9: With ENC_EN = 0, the check field (bits 71..64) is zero and injection still applies. With DEC_EN = 0, `dec_data_o` equals `dec_cw_i[63:0]` and both flags stay low.
- R10: `dec_sbe_o` and `dec_dbe_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | 64 | Data word to encode |
| inj_one_i | input | 1 | Invert one codeword bit |
| inj_two_i | input | 1 | Invert two codeword bits |
| inj_pos_a_i | input | 7 | First bit position to invert |
| inj_pos_b_i | input | 7 | Second bit position to invert |
| enc_cw_o | output | 72 | Encoded codeword, after injection |
| dec_cw_i | input | 72 | Codeword read back for decoding |
| dec_data_o | output | 64 | Corrected data |
| dec_sbe_o | output | 1 | A single error was found and corrected |
| dec_dbe_o | output | 1 | A double error was detected; data is not corrected |

## Verification
The bench inverts every one of the 72 codeword positions for several data patterns. A wrong check-bit mask would show up here as a corrected word that differs from the original. Confusing a check-bit syndrome with a data position would make the decoder flip a healthy data bit. The bench then sweeps every pair of positions: a decoder that ignores overall parity would "correct" these words into wrong data instead of flagging them. It also covers an error in the parity bit alone and injection positions that lie out of range. On the registered variant it checks that the outputs hold their old value until the next clock edge, which catches a register that was dropped or added.

// File: rtl/ecc64_codec.sv
module ecc64_codec #(
  parameter int DW = 64,
  parameter int HW = 7,
  parameter bit ENC_EN = 1'b1,
  parameter bit DEC_EN = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int CW = DW + HW + 1,
  localparam int PW = $clog2(CW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] enc_data_i,
  input  logic          inj_one_i,
  input  logic          inj_two_i,
  input  logic [PW-1:0] inj_pos_a_i,
  input  logic [PW-1:0] inj_pos_b_i,
  output logic [CW-1:0] enc_cw_o,
  input  logic [CW-1:0] dec_cw_i,
  output logic [DW-1:0] dec_data_o,
  output logic          dec_sbe_o,
  output logic          dec_dbe_o
);

  function automatic int hpos(int idx);
    int r = 0;
    int n = 0;
    for (int p = 3; p < (1 << HW); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = p;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] kmask(int k);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = ((hpos(i) >> k) & 1) != 0;
    return m;
  endfunction

  logic [HW-1:0] chk, syn;
  logic [DW-1:0] fix, dd;
  logic [CW-1:0] raw, fa, fb;
  logic          par, sbe, dbe;

  for (genvar k = 0; k < HW; k++) begin : g_par
    localparam logic [DW-1:0] M = kmask(k);
    assign chk[k] = ^(enc_data_i & M);
    assign syn[k] = ^(dec_cw_i[DW-1:0] & M) ^ dec_cw_i[DW+k];
  end

  if (ENC_EN) begin : g_enc
    assign raw = {^{chk, enc_data_i}, chk, enc_data_i};
  end else begin : g_noenc
    assign raw = {{(HW+1){1'b0}}, enc_data_i};
  end

  assign fa = {{(CW-1){1'b0}}, 1'b1} << inj_pos_a_i;
  assign fb = {{(CW-1){1'b0}}, 1'b1} << inj_pos_b_i;
  assign enc_cw_o = raw ^ (inj_two_i ? (fa | fb) : (inj_one_i ? fa : '0));

  assign par = ^dec_cw_i;

  if (DEC_EN) begin : g_dec
    assign sbe = par;
    assign dbe = !par && (syn != '0);
    for (genvar i = 0; i < DW; i++) begin : g_fix
      localparam int P = hpos(i);
      assign fix[i] = sbe && (syn == HW'(P));
    end
  end else begin : g_nodec
    assign sbe = 1'b0;
    assign dbe = 1'b0;
    assign fix = '0;
  end

  assign dd = dec_cw_i[DW-1:0] ^ fix;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dec_data_o <= '0;
        dec_sbe_o  <= 1'b0;
        dec_dbe_o  <= 1'b0;
      end else begin
        dec_data_o <= dd;
        dec_sbe_o  <= sbe;
        dec_dbe_o  <= dbe;
      end
    end
  end else begin : g_comb
    assign dec_data_o = dd;
    assign dec_sbe_o  = sbe;
    assign dec_dbe_o  = dbe;
  end

endmodule

module ecc64_codec_chk #(
  parameter int DW = 64,
  parameter int HW = 7,
  parameter bit ENC_EN = 1'b1,
  parameter bit DEC_EN = 1'b1,
  parameter bit OUT_REG = 1'b1,
  localparam int CW = DW + HW + 1,
  localparam int PW = $clog2(CW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] enc_data_i,
  input logic          inj_one_i,
  input logic          inj_two_i,
  input logic [PW-1:0] inj_pos_a_i,
  input logic [CW-1:0] enc_cw_o,
  input logic [CW-1:0] dec_cw_i,
  input logic          dec_sbe_o,
  input logic          dec_dbe_o
);

  // R10
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_sbe_o && dec_dbe_o));

  // R1
  enc_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_one_i && !inj_two_i) |-> enc_cw_o[DW-1:0] == enc_data_i);

  if (ENC_EN) begin : g_enc
    // R1
    enc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!inj_one_i && !inj_two_i) |-> !(^enc_cw_o));
    // R2
    inj_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_one_i && !inj_two_i && inj_pos_a_i < PW'(CW)) |-> (^enc_cw_o));
  end

  if (DEC_EN && OUT_REG) begin : g_dreg
    // R7
    odd_not_dbe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^dec_cw_i) |=> !dec_dbe_o);
  end else if (DEC_EN) begin : g_dcomb
    // R7
    odd_not_dbe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (^dec_cw_i) |-> !dec_dbe_o);
  end else begin : g_nodec
    // R9
    no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_sbe_o && !dec_dbe_o);
  end

endmodule

bind ecc64_codec ecc64_codec_chk #(
  .DW(DW), .HW(HW), .ENC_EN(ENC_EN), .DEC_EN(DEC_EN), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enc_data_i(enc_data_i), .inj_one_i(inj_one_i),
  .inj_two_i(inj_two_i), .inj_pos_a_i(inj_pos_a_i), .enc_cw_o(enc_cw_o),
  .dec_cw_i(dec_cw_i), .dec_sbe_o(dec_sbe_o), .dec_dbe_o(dec_dbe_o)
);

// File: tb/sim_ecc64_codec.sv
`timescale 1ns/1ps
module sim_ecc64_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] data = '0;
  logic        one = 1'b0, two = 1'b0;
  logic [6:0]  pa = '0, pb = '0;
  logic [71:0] dcw = '0;
  logic [71:0] cw0, cw1, cw2;
  logic [63:0] q0, q1, q2;
  logic        s0, s1, s2, e0, e1, e2;
  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [65:0] prev;

  always #2 clk = ~clk;

  ecc64_codec u0 (.clk, .rst_n, .enc_data_i(data), .inj_one_i(one), .inj_two_i(two),
    .inj_pos_a_i(pa), .inj_pos_b_i(pb), .enc_cw_o(cw0), .dec_cw_i(dcw),
    .dec_data_o(q0), .dec_sbe_o(s0), .dec_dbe_o(e0));
  ecc64_codec #(.OUT_REG(1'b0)) u1 (.clk, .rst_n, .enc_data_i(data), .inj_one_i(one),
    .inj_two_i(two), .inj_pos_a_i(pa), .inj_pos_b_i(pb), .enc_cw_o(cw1), .dec_cw_i(dcw),
    .dec_data_o(q1), .dec_sbe_o(s1), .dec_dbe_o(e1));
  ecc64_codec #(.ENC_EN(1'b0), .DEC_EN(1'b0), .OUT_REG(1'b0)) u2 (.clk, .rst_n,
    .enc_data_i(data), .inj_one_i(one), .inj_two_i(two), .inj_pos_a_i(pa),
    .inj_pos_b_i(pb), .enc_cw_o(cw2), .dec_cw_i(dcw), .dec_data_o(q2),
    .dec_sbe_o(s2), .dec_dbe_o(e2));

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bpos(int idx);
    int p = 2;
    int n = -1;
    while (n < idx) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  function automatic logic [71:0] ref_cw(logic [63:0] d);
    logic [71:0] c = {8'b0, d};
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 7; k++)
        if (bpos(i) & (1 << k)) c[64+k] = c[64+k] ^ d[i];
    c[71] = ^c[70:0];
    return c;
  endfunction

  function automatic logic [71:0] flips(bit o, bit t, int a, int b);
    logic [71:0] f = '0;
    if (t) begin
      if (a < 72) f[a] = 1'b1;
      if (b < 72) f[b] = 1'b1;
    end else if (o && a < 72) f[a] = 1'b1;
    return f;
  endfunction

  // kind: 0 clean, 1 single, 2 double
  task automatic run(input logic [63:0] d, input bit o, input bit t, input int a, input int b, input int kind, input string req);
    logic [71:0] f, ecw, exp_dec;
    @(negedge clk);
    chk({s0, e0, q0} == prev, "R8 registered", {6'b0, s0, e0, q0}, {6'b0, prev});
    data = d; one = o; two = t; pa = 7'(a); pb = 7'(b);
    #0.5;
    f = flips(o, t, a, b);
    ecw = ref_cw(d) ^ f;
    chk(cw0 == ecw, (kind == 0) ? "R1 encode" : (t ? "R3 inject" : "R2 inject"), cw0, ecw);
    chk(cw2 == ({8'b0, d} ^ f), "R9 encode off", cw2, {8'b0, d} ^ f);
    dcw = cw0;
    #0.5;
    if (kind == 2) exp_dec = {6'b0, 2'b01, ecw[63:0]};
    else exp_dec = {6'b0, kind == 1, 1'b0, d};
    chk({s1, e1, q1} == exp_dec[65:0], req, {6'b0, s1, e1, q1}, exp_dec);
    chk({s2, e2, q2} == {2'b00, ecw[63:0]}, "R9 decode off", {6'b0, s2, e2, q2}, {8'b0, ecw[63:0]});
    chk({s0, e0, q0} == prev, "R8 latency", {6'b0, s0, e0, q0}, {6'b0, prev});
    chk(!(s1 && e1), "R10 exclusive", {70'b0, s1, e1}, 72'b0);
    prev = exp_dec[65:0];
  endtask

  initial begin
    logic [63:0] pats [4];
    pats[0] = '0; pats[1] = '1; pats[2] = 64'hA5A5_0F0F_3C3C_9669;
    pats[3] = 64'h9E37_79B9_7F4A_7C15;
    prev = '0;
    repeat (3) @(negedge clk);
    chk({s0, e0, q0} == 66'b0, "R8 reset", {6'b0, s0, e0, q0}, 72'b0);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      run(pats[p], 0, 0, 0, 0, 0, "R4 clean");
      for (int a = 0; a < 71; a++) run(pats[p], 1, 0, a, 0, 1, "R5 single");
      run(pats[p], 1, 0, 71, 0, 1, "R6 parity bit");
      run(pats[p], 1, 0, 72 + p, 0, 0, "R2 out of range");
    end
    for (int p = 2; p < 4; p++)
      for (int a = 0; a < 72; a++)
        for (int b = a + 1; b < 72; b++) run(pats[p], 0, 1, a, b, 2, "R7 double");
    run(pats[1], 1, 1, 5, 40, 2, "R3 precedence");
    run(pats[0], 1, 1, 71, 0, 2, "R3 precedence");
    run(pats[2], 0, 0, 0, 0, 0, "R4 clean");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule